// File: doc/BRIEF.md
# Priority-Masked Interrupt Resolver

This block decides which of a set of normal interrupt sources should be reported to a processor and whether the normal interrupt line should be raised at all. A caller presents the set of sources that are currently active (pending, enabled and routed as normal rather than fast), a packed field of 4-bit priorities (one per source) and a 5-bit threshold. The block finds the winning source and reports its number and priority, packed into a 32-bit vector word for read-back. It also reports whether the interrupt line should be asserted under the threshold.

Each request is taken through a ready/valid handshake and handled by a three-state controller. `ST_IDLE` accepts a request and moves to `ST_RESOLVE` (transition *accept*). `ST_RESOLVE` registers the result of a balanced comparison tree and always moves to `ST_HOLD` (transition *publish*). `ST_HOLD` presents the result until the consumer takes it, then returns to `ST_IDLE` (transition *release*). While the consumer stalls, `ST_HOLD` stays where it is (transition *stall*). The inputs are captured on acceptance, so the caller may change them while a request is in flight.

Top module: `priority_mask_resolver`

## Requirements
- R1: The priority of source n is read from bits [4n+3:4n] of `prio_flat`. This is the same as packing eight priorities per 32-bit word, with source n in nibble n%8 of word n/8.
- R2: Among the active sources, the winner is the one with the largest priority value.
- R3: When several active sources share the largest priority, the source with the highest number wins.
- R4: When a winner exists, `vector` holds the source number zero-extended in bits 31:16 and the priority zero-extended in bits 15:0, and `win_found` is 1. When no source is active, `vector` is 0xFFFFFFFF, `win_found` is 0, and `win_id` and `win_prio` are 0.
- R5: For a mask value other than 31, `irq_assert` is 1 only if some active source has a priority strictly greater than the mask. A mask from 16 to 30 therefore never asserts.
- R6: For a mask value of 31, `irq_assert` equals whether any source is active, regardless of priority.
- R7: With no active source, `irq_assert` is 0 for every mask value.
- R8: A source with priority 0 wins the vector when it is the only active source, even when the threshold keeps `irq_assert` low.
- R9: `in_ready` is 1 only in `ST_IDLE`. `out_valid` rises exactly two clock edges after the edge that accepts a request. While `out_valid` is 1 and `out_ready` is 0, all result outputs hold steady. The edge on which `out_ready` is seen returns the block to `ST_IDLE`.
- R10: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| req_active | input | NUM_SRC | Active normal sources, one bit per source |
| prio_flat | input | NUM_SRC*PRIO_W | Packed per-source priorities |
| mask | input | MASK_W | Threshold; all ones bypasses it |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| irq_assert | output | 1 | Normal interrupt line decision |
| win_found | output | 1 | Some source was active |
| win_id | output | $clog2(NUM_SRC) | Winning source number |
| win_prio | output | PRIO_W | Winning priority |
| vector | output | 32 | Packed read-back word |

## Verification
A fault in the comparison tree shows up as a wrong `win_id` or `win_prio` in the very result it belongs to. A tie resolved toward the lower-numbered source is visible as soon as equal-priority sources are active together. A fault in the threshold gate shows as a wrong `irq_assert` at the first mask boundary, where the mask equals the top active priority or is 31. A controller fault in state sequencing shows within one request as wrong latency, a result that changes during a stall, or `in_ready` high while busy.

// File: rtl/irs_pkg.sv
package irs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESOLVE,
        ST_HOLD
    } irs_state_e;

    localparam int VEC_W    = 32;
    localparam int VEC_HALF = VEC_W / 2;
endpackage

// File: rtl/irs_arb_node.sv
// One comparison node: the right input covers higher-numbered sources,
// so it wins on equal priority.
module irs_arb_node #(
    parameter int ID_W   = 6,
    parameter int PRIO_W = 4
) (
    input  logic              l_v,
    input  logic [ID_W-1:0]   l_id,
    input  logic [PRIO_W-1:0] l_p,
    input  logic              r_v,
    input  logic [ID_W-1:0]   r_id,
    input  logic [PRIO_W-1:0] r_p,
    output logic              o_v,
    output logic [ID_W-1:0]   o_id,
    output logic [PRIO_W-1:0] o_p
);
    logic take_r;

    always_comb begin
        take_r = r_v && (!l_v || (r_p >= l_p));
        o_v    = l_v || r_v;
        o_id   = take_r ? r_id : l_id;
        o_p    = take_r ? r_p  : l_p;
    end
endmodule

// File: rtl/irs_tree.sv
// Balanced tournament over all sources, heap-indexed: node i has children
// 2i+1 (lower sources) and 2i+2 (higher sources); leaves start at NUM_SRC-1.
module irs_tree #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        active,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      found,
    output logic [ID_W-1:0]           id,
    output logic [PRIO_W-1:0]         prio
);
    localparam int NODES = 2 * NUM_SRC - 1;
    localparam int FIRST_LEAF = NUM_SRC - 1;

    logic              nv  [NODES];
    logic [ID_W-1:0]   nid [NODES];
    logic [PRIO_W-1:0] np  [NODES];

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_leaf
        assign nv[FIRST_LEAF+n]  = active[n];
        assign nid[FIRST_LEAF+n] = ID_W'(n);
        assign np[FIRST_LEAF+n]  = prio_flat[n*PRIO_W +: PRIO_W];
    end

    for (genvar i = 0; i < FIRST_LEAF; i++) begin : g_node
        irs_arb_node #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_node (
            .l_v (nv[2*i+1]),  .l_id(nid[2*i+1]), .l_p(np[2*i+1]),
            .r_v (nv[2*i+2]),  .r_id(nid[2*i+2]), .r_p(np[2*i+2]),
            .o_v (nv[i]),      .o_id(nid[i]),     .o_p(np[i])
        );
    end

    assign found = nv[0];
    assign id    = nv[0] ? nid[0] : '0;
    assign prio  = nv[0] ? np[0]  : '0;
endmodule

// File: rtl/irs_gate.sv
// Threshold decision from the winning priority (the maximum active one).
module irs_gate #(
    parameter int PRIO_W = 4,
    parameter int MASK_W = 5
) (
    input  logic              found,
    input  logic [PRIO_W-1:0] prio,
    input  logic [MASK_W-1:0] mask,
    output logic              irq
);
    localparam int CMP_W = (PRIO_W > MASK_W) ? PRIO_W : MASK_W;
    localparam logic [MASK_W-1:0] BYPASS = '1;

    logic [CMP_W-1:0] p_ext;
    logic [CMP_W-1:0] m_ext;

    always_comb begin
        p_ext = CMP_W'(prio);
        m_ext = CMP_W'(mask);
        if (!found)
            irq = 1'b0;
        else if (mask == BYPASS)
            irq = 1'b1;
        else
            irq = (p_ext > m_ext);
    end
endmodule

// File: rtl/irs_ctrl.sv
module irs_ctrl
    import irs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load_in,
    output logic load_out
);
    irs_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (in_valid)  state_d = ST_RESOLVE;   // accept
            ST_RESOLVE:                state_d = ST_HOLD;      // publish
            ST_HOLD:    if (out_ready) state_d = ST_IDLE;      // release
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load_in   = 1'b0;
        load_out  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                load_in  = in_valid;
            end
            ST_RESOLVE: load_out  = 1'b1;
            ST_HOLD:    out_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/priority_mask_resolver.sv
module priority_mask_resolver
    import irs_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int MASK_W  = 5,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [NUM_SRC-1:0]        req_active,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [MASK_W-1:0]         mask,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic                      irq_assert,
    output logic                      win_found,
    output logic [ID_W-1:0]           win_id,
    output logic [PRIO_W-1:0]         win_prio,
    output logic [VEC_W-1:0]          vector
);
    logic                      load_in, load_out;
    logic [NUM_SRC-1:0]        cap_active;
    logic [NUM_SRC*PRIO_W-1:0] cap_prio;
    logic [MASK_W-1:0]         cap_mask;
    logic                      t_found, t_irq;
    logic [ID_W-1:0]           t_id;
    logic [PRIO_W-1:0]         t_prio;
    logic [VEC_W-1:0]          t_vec;

    irs_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .out_ready(out_ready),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .load_in  (load_in),
        .load_out (load_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_active <= '0;
            cap_prio   <= '0;
            cap_mask   <= '1;
        end else if (load_in) begin
            cap_active <= req_active;
            cap_prio   <= prio_flat;
            cap_mask   <= mask;
        end
    end

    irs_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_tree (
        .active   (cap_active),
        .prio_flat(cap_prio),
        .found    (t_found),
        .id       (t_id),
        .prio     (t_prio)
    );

    irs_gate #(.PRIO_W(PRIO_W), .MASK_W(MASK_W)) u_gate (
        .found(t_found),
        .prio (t_prio),
        .mask (cap_mask),
        .irq  (t_irq)
    );

    always_comb begin
        if (t_found)
            t_vec = {VEC_HALF'(t_id), VEC_HALF'(t_prio)};
        else
            t_vec = '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_assert <= 1'b0;
            win_found  <= 1'b0;
            win_id     <= '0;
            win_prio   <= '0;
            vector     <= '1;
        end else if (load_out) begin
            irq_assert <= t_irq;
            win_found  <= t_found;
            win_id     <= t_id;
            win_prio   <= t_prio;
            vector     <= t_vec;
        end
    end
endmodule

// File: rtl/irs_checker.sv
module irs_checker #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int MASK_W  = 5,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic                 irq_assert,
    input logic                 win_found,
    input logic [ID_W-1:0]      win_id,
    input logic [PRIO_W-1:0]    win_prio,
    input logic [31:0]          vector,
    input logic [NUM_SRC-1:0]   cap_active,
    input logic [MASK_W-1:0]    cap_mask
);
    localparam logic [MASK_W-1:0] ALL1 = '1;

    assert_winner_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && win_found |-> cap_active[win_id]);

    assert_empty_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !win_found |-> vector == 32'hFFFF_FFFF);

    assert_threshold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && irq_assert && cap_mask != ALL1 |-> {1'b0, win_prio} > cap_mask);

    assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && cap_mask == ALL1 |-> irq_assert == win_found);

    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !win_found |-> !irq_assert);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(vector) && $stable(irq_assert));

    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && in_ready));
endmodule

bind priority_mask_resolver irs_checker #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W)
) u_irs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .irq_assert(irq_assert),
    .win_found (win_found),
    .win_id    (win_id),
    .win_prio  (win_prio),
    .vector    (vector),
    .cap_active(cap_active),
    .cap_mask  (cap_mask)
);

// File: tb/tb_priority_mask_resolver.sv
module tb_priority_mask_resolver;
    localparam int N  = 64;
    localparam int PW = 4;
    localparam int MW = 5;
    localparam int IW = 6;

    typedef struct packed {
        logic [N-1:0] act;
        logic [7:0]   seed;
        logic [MW-1:0] msk;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TABLE [NV] = '{
        '{act: 64'h0000_0000_0000_0001, seed: 8'h13, msk: 5'd0},
        '{act: 64'h8000_0000_0000_0000, seed: 8'h52, msk: 5'd3},
        '{act: 64'hFFFF_FFFF_FFFF_FFFF, seed: 8'h31, msk: 5'd14},
        '{act: 64'h0F0F_0000_F0F0_0000, seed: 8'h77, msk: 5'd31},
        '{act: 64'h0000_1234_5678_0000, seed: 8'h9A, msk: 5'd7},
        '{act: 64'hAAAA_AAAA_5555_5555, seed: 8'hE4, msk: 5'd20},
        '{act: 64'h0000_0000_0000_0000, seed: 8'h21, msk: 5'd2},
        '{act: 64'h0010_0000_0000_8000, seed: 8'hC5, msk: 5'd15}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [N-1:0]      req_active = '0;
    logic [N*PW-1:0]   prio_flat = '0;
    logic [MW-1:0]     mask = '1;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic              irq_assert;
    logic              win_found;
    logic [IW-1:0]     win_id;
    logic [PW-1:0]     win_prio;
    logic [31:0]       vector;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    priority_mask_resolver dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .req_active(req_active), .prio_flat(prio_flat), .mask(mask),
        .out_valid(out_valid), .out_ready(out_ready), .irq_assert(irq_assert),
        .win_found(win_found), .win_id(win_id), .win_prio(win_prio), .vector(vector)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [N*PW-1:0] fill_prio(input logic [7:0] seed);
        logic [N*PW-1:0] p = '0;
        for (int n = 0; n < N; n++)
            p[n*PW +: PW] = PW'(n * (seed[7:4] | 4'd1) + seed[3:0]);
        return p;
    endfunction

    // Independent reference: ascending scan with >= keeps the highest number on ties.
    task automatic ref_model(input logic [N-1:0] a, input logic [N*PW-1:0] p,
                             input logic [MW-1:0] m, output logic f, output int id,
                             output int pr, output logic irq);
        f = 1'b0; id = 0; pr = 0; irq = 1'b0;
        for (int n = 0; n < N; n++) begin
            if (a[n]) begin
                int word = n / 8;
                int pos  = 4 * (n % 8);
                int pv   = int'((p[word*32 +: 32] >> pos) & 32'hF);
                if (!f || pv >= pr) begin
                    f = 1'b1; id = n; pr = pv;
                end
            end
        end
        if (!f)           irq = 1'b0;
        else if (m == 31) irq = 1'b1;
        else              irq = (pr > int'(m));
    endtask

    task automatic run(input logic [N-1:0] a, input logic [N*PW-1:0] p,
                       input logic [MW-1:0] m, input int hold, input string tag);
        logic ef, eirq;
        int eid, epr, lat;
        logic [31:0] evec;
        ref_model(a, p, m, ef, eid, epr, eirq);
        evec = ef ? {16'(eid), 16'(epr)} : 32'hFFFF_FFFF;
        @(negedge clk);
        chk({tag, " R9 idle ready"}, 32'(in_ready), 32'd1);
        in_valid = 1'b1; req_active = a; prio_flat = p; mask = m;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; req_active = ~a; prio_flat = ~p; mask = ~m;
        chk({tag, " R9 busy not ready"}, 32'(in_ready), 32'd0);
        lat = 1;
        while (!out_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk({tag, " R9 latency"}, 32'(lat), 32'd2);
        chk({tag, " R4 found"}, 32'(win_found), 32'(ef));
        chk({tag, " R2 R3 winner id"}, 32'(win_id), 32'(eid));
        chk({tag, " R1 R2 winner prio"}, 32'(win_prio), 32'(epr));
        chk({tag, " R4 vector"}, vector, evec);
        chk({tag, " R5 R6 R7 irq"}, 32'(irq_assert), 32'(eirq));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk({tag, " R9 stall valid"}, 32'(out_valid), 32'd1);
            chk({tag, " R9 stall vector"}, vector, evec);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk({tag, " R9 released"}, 32'(out_valid), 32'd0);
        chk({tag, " R9 ready again"}, 32'(in_ready), 32'd1);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [N*PW-1:0] p;
        logic [N-1:0] a;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R10 in_ready after reset", 32'(in_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 in_ready idle", 32'(in_ready), 32'd1);

        for (int k = 0; k < NV; k++)
            run(TABLE[k].act, fill_prio(TABLE[k].seed), TABLE[k].msk, k % 3, "table");

        // R3: all sources equal priority, highest number wins
        run({N{1'b1}}, {N{4'h6}}, 5'd2, 0, "R3 full tie");
        run(64'h0000_0100_0000_0101, {N{4'h3}}, 5'd3, 0, "R3 partial tie");
        // R1: one distinct nibble placed at source 37 (word 4, nibble 5)
        p = '0; p[37*4 +: 4] = 4'h9;
        run(64'h0000_0030_0000_0001, p, 5'd8, 0, "R1 field position");
        // R8: priority zero alone wins vector, threshold keeps irq low
        run(64'h0000_0000_0400_0000, '0, 5'd0, 0, "R8 zero alone");
        // R6: bypass with priority zero
        run(64'h0000_0000_0400_0000, '0, 5'd31, 0, "R6 bypass zero prio");
        // R5: boundary mask equals top priority, and mask above 15
        p = '0; p[10*4 +: 4] = 4'hF;
        run(64'h0000_0000_0000_0400, p, 5'd15, 0, "R5 equal mask");
        run(64'h0000_0000_0000_0400, p, 5'd14, 0, "R5 one below");
        run(64'h0000_0000_0000_0400, p, 5'd16, 0, "R5 mask 16");
        // R7: nothing active under bypass
        run('0, {N{4'hF}}, 5'd31, 0, "R7 empty bypass");
        // R9: long stall
        run(64'h1, {N{4'h2}}, 5'd1, 5, "R9 long stall");

        for (int r = 0; r < 40; r++) begin
            a = {$urandom, $urandom};
            if (r % 3 == 0) a = a & {$urandom, $urandom} & {$urandom, $urandom};
            for (int w = 0; w < N * PW / 32; w++) p[w*32 +: 32] = $urandom;
            run(a, p, (r % 5 == 0) ? 5'd31 : MW'($urandom % 32), r % 2, "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule